// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This block steps a CPU clock domain safely through a frequency change. Software or a power manager gives it the current rate, the target rate, the rate of an alternate clock parent and a small table of divider settings, one entry per supported target rate. A start pulse with a phase bit runs one of two sequences. The pre-change sequence parks the domain on the alternate parent and loads the divider words for the target rate. The post-change sequence, issued once the main PLL has been retuned, moves the domain back to the PLL path and releases the temporary divide.

While the domain runs from the alternate parent, its clock must stay at or below the lower of the old and new rates. The sequencer therefore computes a temporary divide ratio for the alternate source and applies it before the mux is switched. It talks to the clock control block through a single-cycle register-write port and reads back the current register contents, the divider-busy words and the 3-bit mux state. Every wait on that readback has a programmable cycle limit. When the limit runs out, a sticky flag is raised and the sequence carries on, so the block never hangs.

Top module: `cpu_clk_seq`

## Requirements
- R1: The target rate is looked up as the first table entry equal to `newRate`, scanning upward from entry 0. An entry of rate 0 ends the scan. If no entry matches, the block pulses `done` with `errFlag` high and makes no register write. This applies to every pre-change request, and to post-change requests when the trace-divider option is on.
- R2: A temporary divide is needed only when `altRate > oldRate` or `oldRate > newRate`. Its 3-bit field is ceil(`altRate` / min(`oldRate`, `newRate`)) - 1, which encodes ratios 1 to 8 as 0 to 7. A value of 8 or more sets `warnFlag` and writes 7 into the field.
- R3: When the temporary divide is needed, the first write of a pre-change sequence goes to address 1 (the core divider word). It keeps the current word, replaces bits [2:0] with the temporary field and, with the trace option on, sets bits [18:16] to 7. The block then waits until those masked bits of `divAStat` are zero.
- R4: The source-select register sits at address 0. A pre-change sequence writes it with bit 16 set and waits for `muxState == 2`. A post-change sequence writes it with bit 16 cleared and waits for `muxState == 1`. All other bits keep their current values. Address 3 is never written.
- R5: After the mux switch, the pre-change sequence writes address 1 with the matched entry's core word ORed with the temporary divide bits from R3, or zero when no temporary divide is needed. It then waits until all of `divAStat` is zero.
- R6: With the second divider present, the pre-change sequence next writes address 2 and waits until all of `divBStat` is zero. The value is the matched entry's second word. If source-select bit 20 is currently set, the value is instead the current second word with only bits [6:4] and [2:0] kept.
- R7: After the mux wait, the post-change sequence writes address 1 with bits [2:0] cleared. With the trace option on, bits [18:16] are taken from the matched entry's core word. All other bits keep their current values. The block then waits until the same masked bits of `divAStat` are zero.
- R8: A wait whose status is correct in any of its first `tmoLimit`+1 cycles ends without a flag. If the status is still wrong after that, `tmoFlag` is set and the sequence moves to its next step. A correct status wins over expiry in the same cycle. `errFlag`, `warnFlag` and `tmoFlag` hold until the next accepted start.
- R9: A start pulse is accepted only while `busy` is low, and `busy` is high in the cycle after it. `done` is a one-cycle pulse issued while `busy` is still high, and `busy` is low in the following cycle. A start seen while busy has no effect.
- R10: After reset, `busy`, `done`, `wrEn` and all three flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| phasePost | input | 1 | 0 = pre-change sequence, 1 = post-change sequence |
| oldRate | input | RATE_W | Current CPU rate |
| newRate | input | RATE_W | Target CPU rate |
| altRate | input | RATE_W | Alternate parent rate |
| cfgRate | input | DEPTH*RATE_W | Table rates, entry i at bits [i*RATE_W +: RATE_W] |
| cfgDivA | input | DEPTH*32 | Table core divider words |
| cfgDivB | input | DEPTH*32 | Table second divider words |
| tmoLimit | input | TMO_W | Extra wait cycles allowed per poll |
| curSrc | input | 32 | Current source-select register |
| curDivA | input | 32 | Current core divider register |
| curDivB | input | 32 | Current second divider register |
| muxState | input | 3 | Mux status field |
| divAStat | input | 32 | Core divider busy word |
| divBStat | input | 32 | Second divider busy word |
| wrEn | output | 1 | Register write strobe |
| wrAddr | output | 2 | 0 source select, 1 core divider, 2 second divider |
| wrData | output | 32 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | End-of-sequence pulse |
| errFlag | output | 1 | No table entry matched |
| warnFlag | output | 1 | Temporary ratio saturated |
| tmoFlag | output | 1 | A poll timed out |

## Verification
A poll can see its status turn correct in the very cycle its wait counter reaches `tmoLimit`, so success and timeout expiry land together. The bench sets the modelled busy and mux delays equal to `tmoLimit` to force that overlap and expects no timeout flag. It then repeats the run with the limit one lower and expects the flag, with the full write sequence still produced. A second overlap comes from a start pulse issued in the middle of a running sequence. That run is judged by an unchanged write log and flags.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  localparam int DATA_W = 32;
  localparam int MUX_BIT = 16;
  localparam int HPM_BIT = 20;
  localparam int CORE_LSB = 0;
  localparam int TRACE_LSB = 16;
  localparam logic [DATA_W-1:0] AUX_KEEP = 32'h0000_0077;
  localparam logic [2:0] MUX_ON_ALT = 3'd2;
  localparam logic [2:0] MUX_ON_MAIN = 3'd1;
  localparam logic [1:0] ADDR_SRC = 2'd0;
  localparam logic [1:0] ADDR_DIVA = 2'd1;
  localparam logic [1:0] ADDR_DIVB = 2'd2;

  typedef enum logic [2:0] {
    WK_SAFE, WK_ALT, WK_NEWDIV, WK_AUXDIV, WK_MAIN, WK_CLR
  } stepKind_e;

  typedef struct packed {
    logic latch;
    logic setErr;
    logic wrEn;
    logic pollRun;
    stepKind_e kind;
  } seqStrb_t;
endpackage

// File: rtl/clkseq_datapath.sv
module clkseq_datapath
  import clkseq_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter int DEPTH = 4,
  parameter int TMO_W = 8,
  parameter bit HAS_TRACE = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrb_t                 strb,
  input  logic                     phasePost,
  input  logic [RATE_W-1:0]        oldRate,
  input  logic [RATE_W-1:0]        newRate,
  input  logic [RATE_W-1:0]        altRate,
  input  logic [DEPTH*RATE_W-1:0]  cfgRate,
  input  logic [DEPTH*DATA_W-1:0]  cfgDivA,
  input  logic [DEPTH*DATA_W-1:0]  cfgDivB,
  input  logic [TMO_W-1:0]         tmoLimit,
  input  logic [DATA_W-1:0]        curSrc,
  input  logic [DATA_W-1:0]        curDivA,
  input  logic [DATA_W-1:0]        curDivB,
  input  logic [2:0]               muxState,
  input  logic [DATA_W-1:0]        divAStat,
  input  logic [DATA_W-1:0]        divBStat,
  output logic [1:0]               wrAddr,
  output logic [DATA_W-1:0]        wrData,
  output logic                     phPostQ,
  output logic                     matchOk,
  output logic                     needSafe,
  output logic                     pollOk,
  output logic                     pollExp,
  output logic                     errFlag,
  output logic                     warnFlag,
  output logic                     tmoFlag
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = RATE_W + 4;
  localparam int RATIO_STEPS = 8;
  localparam logic [DATA_W-1:0] CORE_MASK = DATA_W'(7) << CORE_LSB;
  localparam logic [DATA_W-1:0] TRACE_MASK = HAS_TRACE ? (DATA_W'(7) << TRACE_LSB) : '0;
  localparam logic [DATA_W-1:0] SAFE_MASK = CORE_MASK | TRACE_MASK;
  localparam logic [DATA_W-1:0] MUX_SEL = DATA_W'(1) << MUX_BIT;

  logic [RATE_W-1:0] oldQ, newQ, altQ, minQ;
  logic [TMO_W-1:0] pollCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phPostQ <= 1'b0;
      oldQ <= '0;
      newQ <= '0;
      altQ <= '0;
    end else if (strb.latch) begin
      phPostQ <= phasePost;
      oldQ <= oldRate;
      newQ <= newRate;
      altQ <= altRate;
    end
  end

  // Table lookup: per-entry compare, then first hit before a terminator
  logic [DEPTH-1:0] entHit, entEnd;
  logic [IDX_W-1:0] hitIdx;
  logic stopScan;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : gEnt
      assign entHit[g] = (cfgRate[g*RATE_W +: RATE_W] == newQ);
      assign entEnd[g] = (cfgRate[g*RATE_W +: RATE_W] == '0);
    end
  endgenerate

  always_comb begin
    matchOk = 1'b0;
    hitIdx = '0;
    stopScan = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!stopScan) begin
        if (entEnd[i]) begin
          stopScan = 1'b1;
        end else if (entHit[i]) begin
          matchOk = 1'b1;
          hitIdx = IDX_W'(i);
          stopScan = 1'b1;
        end
      end
    end
  end

  logic [DATA_W-1:0] hitDivA, hitDivB;
  assign hitDivA = cfgDivA[hitIdx*DATA_W +: DATA_W];
  assign hitDivB = cfgDivB[hitIdx*DATA_W +: DATA_W];

  // Temporary ratio: count n in 1..8 with n*min < alt
  logic [RATIO_STEPS-1:0] below;
  logic [3:0] ratioCnt;
  logic safeOver;
  logic [2:0] safeField;
  logic [DATA_W-1:0] safeWord;

  assign minQ = (oldQ < newQ) ? oldQ : newQ;
  assign needSafe = (altQ > oldQ) || (oldQ > newQ);

  generate
    for (g = 0; g < RATIO_STEPS; g++) begin : gRatio
      assign below[g] = (PW'(minQ) * PW'(g + 1)) < PW'(altQ);
    end
  endgenerate

  assign ratioCnt = 4'($countones(below));
  assign safeOver = ratioCnt[3];
  assign safeField = safeOver ? 3'd7 : ratioCnt[2:0];
  assign safeWord = needSafe ? ((DATA_W'(safeField) << CORE_LSB) | TRACE_MASK) : '0;

  always_comb begin
    wrAddr = ADDR_DIVA;
    wrData = '0;
    case (strb.kind)
      WK_SAFE:   wrData = (curDivA & ~SAFE_MASK) | safeWord;
      WK_ALT:    begin wrAddr = ADDR_SRC; wrData = curSrc | MUX_SEL; end
      WK_NEWDIV: wrData = hitDivA | safeWord;
      WK_AUXDIV: begin
        wrAddr = ADDR_DIVB;
        wrData = curSrc[HPM_BIT] ? (curDivB & AUX_KEEP) : hitDivB;
      end
      WK_MAIN:   begin wrAddr = ADDR_SRC; wrData = curSrc & ~MUX_SEL; end
      WK_CLR:    wrData = (curDivA & ~SAFE_MASK) | (hitDivA & TRACE_MASK);
      default:   wrData = '0;
    endcase
  end

  always_comb begin
    case (strb.kind)
      WK_SAFE, WK_CLR: pollOk = ((divAStat & SAFE_MASK) == '0);
      WK_ALT:          pollOk = (muxState == MUX_ON_ALT);
      WK_MAIN:         pollOk = (muxState == MUX_ON_MAIN);
      WK_NEWDIV:       pollOk = (divAStat == '0);
      WK_AUXDIV:       pollOk = (divBStat == '0);
      default:         pollOk = 1'b1;
    endcase
  end

  assign pollExp = (pollCnt == tmoLimit);

  always_ff @(posedge clk) begin
    if (!rstN || strb.wrEn) begin
      pollCnt <= '0;
    end else if (strb.pollRun && !pollOk && !pollExp) begin
      pollCnt <= pollCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.latch) begin
      errFlag <= 1'b0;
      warnFlag <= 1'b0;
      tmoFlag <= 1'b0;
    end else begin
      if (strb.setErr) errFlag <= 1'b1;
      if (strb.wrEn && strb.kind == WK_SAFE && safeOver) warnFlag <= 1'b1;
      if (strb.pollRun && !pollOk && pollExp) tmoFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/clkseq_ctrl.sv
module clkseq_ctrl
  import clkseq_pkg::*;
#(
  parameter bit HAS_AUX = 1'b1,
  parameter bit HAS_TRACE = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     phPostQ,
  input  logic     matchOk,
  input  logic     needSafe,
  input  logic     pollOk,
  input  logic     pollExp,
  output seqStrb_t strb,
  output logic     busy,
  output logic     done
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_WRITE, S_POLL, S_FINISH} seqState_e;

  seqState_e stateQ, stateD;
  stepKind_e kindQ, kindD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      kindQ <= WK_SAFE;
    end else begin
      stateQ <= stateD;
      kindQ <= kindD;
    end
  end

  always_comb begin
    strb = '0;
    strb.kind = kindQ;
    stateD = stateQ;
    kindD = kindQ;
    case (stateQ)
      S_IDLE: begin
        if (start) begin
          strb.latch = 1'b1;
          stateD = S_CHECK;
        end
      end
      S_CHECK: begin
        if ((!phPostQ || HAS_TRACE) && !matchOk) begin
          strb.setErr = 1'b1;
          stateD = S_FINISH;
        end else begin
          stateD = S_WRITE;
          kindD = phPostQ ? WK_MAIN : (needSafe ? WK_SAFE : WK_ALT);
        end
      end
      S_WRITE: begin
        strb.wrEn = 1'b1;
        stateD = S_POLL;
      end
      S_POLL: begin
        strb.pollRun = 1'b1;
        if (pollOk || pollExp) begin
          stateD = S_WRITE;
          case (kindQ)
            WK_SAFE:   kindD = WK_ALT;
            WK_ALT:    kindD = WK_NEWDIV;
            WK_NEWDIV: begin
              if (HAS_AUX) kindD = WK_AUXDIV;
              else stateD = S_FINISH;
            end
            WK_MAIN:   kindD = WK_CLR;
            default:   stateD = S_FINISH;
          endcase
        end
      end
      S_FINISH: stateD = S_IDLE;
      default:  stateD = S_IDLE;
    endcase
  end

  assign busy = (stateQ != S_IDLE);
  assign done = (stateQ == S_FINISH);
endmodule

// File: rtl/cpu_clk_seq.sv
module cpu_clk_seq
  import clkseq_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter int DEPTH = 4,
  parameter int TMO_W = 8,
  parameter bit HAS_AUX = 1'b1,
  parameter bit HAS_TRACE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    phasePost,
  input  logic [RATE_W-1:0]       oldRate,
  input  logic [RATE_W-1:0]       newRate,
  input  logic [RATE_W-1:0]       altRate,
  input  logic [DEPTH*RATE_W-1:0] cfgRate,
  input  logic [DEPTH*32-1:0]     cfgDivA,
  input  logic [DEPTH*32-1:0]     cfgDivB,
  input  logic [TMO_W-1:0]        tmoLimit,
  input  logic [31:0]             curSrc,
  input  logic [31:0]             curDivA,
  input  logic [31:0]             curDivB,
  input  logic [2:0]              muxState,
  input  logic [31:0]             divAStat,
  input  logic [31:0]             divBStat,
  output logic                    wrEn,
  output logic [1:0]              wrAddr,
  output logic [31:0]             wrData,
  output logic                    busy,
  output logic                    done,
  output logic                    errFlag,
  output logic                    warnFlag,
  output logic                    tmoFlag
);
  seqStrb_t strb;
  logic phPostQ, matchOk, needSafe, pollOk, pollExp;

  clkseq_ctrl #(.HAS_AUX(HAS_AUX), .HAS_TRACE(HAS_TRACE)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .phPostQ(phPostQ),
    .matchOk(matchOk), .needSafe(needSafe), .pollOk(pollOk), .pollExp(pollExp),
    .strb(strb), .busy(busy), .done(done)
  );

  clkseq_datapath #(.RATE_W(RATE_W), .DEPTH(DEPTH), .TMO_W(TMO_W), .HAS_TRACE(HAS_TRACE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .phasePost(phasePost),
    .oldRate(oldRate), .newRate(newRate), .altRate(altRate),
    .cfgRate(cfgRate), .cfgDivA(cfgDivA), .cfgDivB(cfgDivB), .tmoLimit(tmoLimit),
    .curSrc(curSrc), .curDivA(curDivA), .curDivB(curDivB), .muxState(muxState),
    .divAStat(divAStat), .divBStat(divBStat),
    .wrAddr(wrAddr), .wrData(wrData), .phPostQ(phPostQ), .matchOk(matchOk),
    .needSafe(needSafe), .pollOk(pollOk), .pollExp(pollExp),
    .errFlag(errFlag), .warnFlag(warnFlag), .tmoFlag(tmoFlag)
  );

  assign wrEn = strb.wrEn;
endmodule

// File: rtl/cpu_clk_seq_chk.sv
module cpu_clk_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       wrEn,
  input logic [1:0] wrAddr,
  input logic       errFlag,
  input logic       tmoFlag
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R9
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN) done |-> busy); // R9
  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN) wrEn |-> busy); // R9
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN) (start && !busy) |=> busy); // R9
  AST_ADDR_LEGAL: assert property (@(posedge clk) disable iff (!rstN) wrEn |-> (wrAddr != 2'd3)); // R4
  AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rstN) $rose(errFlag) |-> (done && !wrEn)); // R1
  AST_WRITE_THEN_POLL: assert property (@(posedge clk) disable iff (!rstN) wrEn |=> !wrEn); // R3
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rstN) (tmoFlag && !(start && !busy)) |=> tmoFlag); // R8
endmodule

bind cpu_clk_seq cpu_clk_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .wrEn(wrEn), .wrAddr(wrAddr), .errFlag(errFlag), .tmoFlag(tmoFlag)
);

// File: tb/cpu_clk_seq_tb.sv
module cpu_clk_seq_tb;
  localparam int RW = 16;
  localparam int DEP = 4;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, phasePost = 1'b0;
  logic [RW-1:0] oldRate = '0, newRate = '0, altRate = '0;
  logic [DEP*RW-1:0] cfgRate = '0;
  logic [DEP*32-1:0] cfgDivA = '0, cfgDivB = '0;
  logic [TW-1:0] tmoLimit = 8'd20;
  logic [31:0] mSrc, mDivA, mDivB;
  logic [2:0] muxState;
  logic [31:0] divAStat, divBStat;
  logic wrEn, busy, done, errFlag, warnFlag, tmoFlag;
  logic [1:0] wrAddr;
  logic [31:0] wrData;

  int checks = 0, errors = 0;
  int dDiv = 1, dMux = 1;
  bit stuck = 0;
  int aCnt = 0, bCnt = 0, mCnt = 0;
  logic pokeReq = 1'b0;
  logic [31:0] pokeSrc = '0, pokeA = '0, pokeB = '0;
  logic logClr = 1'b0;
  logic [1:0] logA [16];
  logic [31:0] logD [16];
  int logN = 0;
  logic [1:0] expA [16];
  logic [31:0] expD [16];
  int expN;
  bit expErr, expWarn;

  always #5 clk = ~clk;

  cpu_clk_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .phasePost(phasePost),
    .oldRate(oldRate), .newRate(newRate), .altRate(altRate),
    .cfgRate(cfgRate), .cfgDivA(cfgDivA), .cfgDivB(cfgDivB), .tmoLimit(tmoLimit),
    .curSrc(mSrc), .curDivA(mDivA), .curDivB(mDivB), .muxState(muxState),
    .divAStat(divAStat), .divBStat(divBStat),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .busy(busy), .done(done),
    .errFlag(errFlag), .warnFlag(warnFlag), .tmoFlag(tmoFlag)
  );

  // Clock control block model
  always @(posedge clk) begin
    if (pokeReq) begin
      mSrc <= pokeSrc; mDivA <= pokeA; mDivB <= pokeB;
      aCnt <= 0; bCnt <= 0; mCnt <= 0;
    end else begin
      if (wrEn && wrAddr == 2'd0) begin mSrc <= wrData; mCnt <= dMux; end
      else if (mCnt != 0) mCnt <= mCnt - 1;
      if (wrEn && wrAddr == 2'd1) begin mDivA <= wrData; aCnt <= dDiv; end
      else if (aCnt != 0) aCnt <= aCnt - 1;
      if (wrEn && wrAddr == 2'd2) begin mDivB <= wrData; bCnt <= dDiv; end
      else if (bCnt != 0) bCnt <= bCnt - 1;
    end
  end

  assign muxState = stuck ? 3'd4 : ((mCnt != 0) ? 3'd0 : (mSrc[16] ? 3'd2 : 3'd1));
  assign divAStat = (aCnt != 0) ? 32'h0007_0007 : 32'h0;
  assign divBStat = (bCnt != 0) ? 32'h0000_0070 : 32'h0;

  always @(posedge clk) begin
    if (logClr) logN <= 0;
    else if (wrEn && logN < 16) begin
      logA[logN] <= wrAddr; logD[logN] <= wrData; logN <= logN + 1;
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      $display("FAIL R9 watchdog expired actual=%0d expected<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] a, input logic [31:0] d);
    expA[expN] = a; expD[expN] = d; expN++;
  endtask

  // Expected sequence from the requirements
  task automatic buildExp(input bit post, input int oldR, input int newR, input int altR);
    int j, m, q, f;
    bit ns;
    logic [31:0] s, a, sw;
    expN = 0; expErr = 0; expWarn = 0; j = -1;
    for (int i = 0; i < DEP; i++) begin
      if (j < 0 && cfgRate[i*RW +: RW] == 0) j = -2;
      if (j == -1 && cfgRate[i*RW +: RW] == newR[RW-1:0]) j = i;
    end
    if (j < 0) begin expErr = 1; return; end
    s = mSrc; a = mDivA;
    if (!post) begin
      ns = (altR > oldR) || (oldR > newR);
      m = (oldR < newR) ? oldR : newR;
      q = (altR + m - 1) / m - 1;
      f = (q >= 8) ? 7 : q;
      expWarn = ns && (q >= 8);
      sw = ns ? (32'(f) | 32'h0007_0000) : 32'h0;
      if (ns) begin a = (a & ~32'h0007_0007) | sw; push(2'd1, a); end
      s = s | 32'h0001_0000; push(2'd0, s);
      push(2'd1, cfgDivA[j*32 +: 32] | sw);
      push(2'd2, s[20] ? (mDivB & 32'h77) : cfgDivB[j*32 +: 32]);
    end else begin
      push(2'd0, s & ~32'h0001_0000);
      push(2'd1, (a & ~32'h0007_0007) | (cfgDivA[j*32 +: 32] & 32'h0007_0000));
    end
  endtask

  task automatic poke(input logic [31:0] s, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    pokeSrc = s; pokeA = a; pokeB = b; pokeReq = 1'b1;
    @(negedge clk);
    pokeReq = 1'b0;
  endtask

  task automatic runSeq(input string tag, input bit post, input int oldR, input int newR,
                        input int altR, input bit extraStart);
    bit seen, expTmo;
    int n;
    buildExp(post, oldR, newR, altR);
    expTmo = !expErr && (dDiv > int'(tmoLimit) || dMux > int'(tmoLimit) || stuck);
    @(negedge clk);
    phasePost = post; oldRate = RW'(oldR); newRate = RW'(newR); altRate = RW'(altR);
    start = 1'b1; logClr = 1'b1;
    @(negedge clk);
    start = 1'b0; logClr = 1'b0;
    chk(busy == 1'b1, "R9", {tag, " busy after start"}, busy, 1);
    seen = 0; n = 0;
    while (!seen && n < 400) begin
      if (done) seen = 1;
      else begin
        start = (extraStart && n == 3);
        if (extraStart && n == 3) phasePost = ~post;
        @(negedge clk);
        start = 1'b0;
        n++;
      end
    end
    chk(seen, "R9", {tag, " done seen"}, seen, 1);
    chk(errFlag == expErr, "R1", {tag, " errFlag"}, errFlag, expErr);
    chk(warnFlag == expWarn, "R2", {tag, " warnFlag"}, warnFlag, expWarn);
    chk(tmoFlag == expTmo, "R8", {tag, " tmoFlag"}, tmoFlag, expTmo);
    chk(logN == expN, post ? "R7" : "R5", {tag, " write count"}, logN, expN);
    for (int i = 0; i < expN && i < logN; i++) begin
      chk(logA[i] == expA[i], "R4", {tag, " write address"}, logA[i], expA[i]);
      chk(logD[i] == expD[i], post ? "R7" : (expA[i] == 2'd2 ? "R6" : "R3"),
          {tag, " write data"}, logD[i], expD[i]);
    end
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9", {tag, " done pulse ends"}, {done, busy}, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    cfgRate = {16'd400, 16'd0, 16'd200, 16'd100};
    for (int i = 0; i < DEP; i++) begin
      cfgDivA[i*32 +: 32] = $urandom();
      cfgDivB[i*32 +: 32] = $urandom();
    end
    pokeSrc = 32'h0; pokeA = 32'h0; pokeB = 32'h0; pokeReq = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && wrEn == 0, "R10", "reset outputs", {busy, done, wrEn}, 0);
    chk(errFlag == 0 && warnFlag == 0 && tmoFlag == 0, "R10", "reset flags",
        {errFlag, warnFlag, tmoFlag}, 0);
    pokeReq = 1'b0;
    rstN = 1'b1;

    // Directed corners
    poke(32'h0000_1234, 32'h1111_1111, 32'h2222_2222);
    runSeq("down_safe", 0, 200, 100, 150, 0);        // R2 ratio 1
    runSeq("post_back", 1, 200, 100, 150, 0);        // R4 R7
    runSeq("up_nosafe", 0, 100, 200, 80, 0);         // R2 not needed
    runSeq("ratio_sat", 0, 100, 200, 1000, 0);       // R2 warn, field 7
    runSeq("ratio_exact", 0, 100, 200, 300, 0);      // R2 exact multiple
    runSeq("ratio_edge7", 0, 100, 200, 800, 0);      // R2 ratio 8 -> 7, no warn
    runSeq("ratio_edge8", 0, 100, 200, 801, 0);      // R2 saturates
    runSeq("past_end", 0, 100, 400, 150, 0);         // R1 entry after terminator
    runSeq("no_entry", 0, 100, 123, 150, 0);         // R1
    runSeq("post_no_entry", 1, 100, 123, 150, 0);    // R1
    poke(32'h0011_0000, 32'hABCD_0000, 32'hFFFF_FFFF);
    runSeq("hpm_keep", 0, 100, 200, 150, 0);         // R6
    runSeq("busy_start", 0, 200, 100, 150, 1);       // R9 start ignored
    // Poll success and expiry in the same cycle
    dDiv = 2; dMux = 2; tmoLimit = 8'd2;
    runSeq("tie_no_tmo", 0, 200, 100, 150, 0);       // R8
    tmoLimit = 8'd1;
    runSeq("late_tmo", 0, 200, 100, 150, 0);         // R8
    tmoLimit = 8'd5; stuck = 1;
    runSeq("stuck_mux", 0, 200, 100, 150, 0);        // R8 continues
    stuck = 0;

    // Constrained random
    for (int it = 0; it < 80; it++) begin
      int rates [3];
      int o, nw, al;
      rates[0] = 100; rates[1] = 200; rates[2] = 123;
      o = rates[$urandom_range(0, 1)];
      nw = rates[$urandom_range(0, 2)];
      al = $urandom_range(50, 1000);
      dDiv = $urandom_range(0, 3); dMux = $urandom_range(0, 3);
      tmoLimit = TW'($urandom_range(0, 4));
      poke($urandom(), $urandom(), $urandom());
      runSeq("random", $urandom_range(0, 1) == 1, o, nw, al, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule